// File: doc/BRIEF.md
# Waveform Timer/Counter Channel

This block is a single up-counting timer channel with a register interface. A mode register picks the count clock. It can be one of five fixed divisions of the system clock or one of three external clock pins. That clock can be inverted so counting follows the falling edge, and it can be gated by the level of an external pin. The counter counts up and returns to zero on the tick after it reaches the RC compare value. Each compare event drives a waveform pin: reaching RA sets it, and reaching RC clears it.

Software starts the channel, stops it and restarts it through a control register. An edge on the trigger pin can also restart it, and the edge that does so is selectable. A one-shot option stops the count clock when the counter reaches RC. Two status flags record RC compares and counter overflows. Reading status clears them. A set/clear interrupt mask decides which flags drive the interrupt line. External pins are synchronised to the system clock, so channels can be chained by connecting one channel's waveform pin to another channel's clock or trigger pin.

Top module: `tcw_channel`

## Requirements
- R1: After reset the counter is 0, wave_out and irq are low, the status flags, the interrupt mask, RA, RC and the mode register are 0, and the count clock is disabled.
- R2: A control write (address 0) with bit0 set enables the count clock. Bit1 disables it. When bit0 and bit1 are written together, the clock ends up disabled. Enabling without a trigger keeps the current count, and while the clock is disabled the counter holds.
- R3: Mode bits [2:0] select the count clock. Values 0 to 4 select the system clock divided by 2, 8, 32, 128 and 1024. Values 5, 6 and 7 select ext_clk[0], ext_clk[1] and ext_clk[2], giving one count per synchronised rising edge.
- R4: Mode bit 3 inverts the selected clock, so the counter advances on its falling edge and not on its rising edge.
- R5: Mode bits [5:4] select gating. Value 0 means no gating. Values 1 to 3 let a tick through only while ext_clk[0], ext_clk[1] or ext_clk[2] respectively is high.
- R6: Each enabled tick increments the counter. A tick taken while the counter equals RC loads 0. Reaching RC sets status bit0.
- R7: wave_out goes high when the counter reaches RA and low when it reaches RC. When RA equals RC, the clear wins. Any trigger drives wave_out low.
- R8: With mode bit 8 set, reaching RC disables the count clock, so the counter stays at RC. Only a new enable command resumes counting.
- R9: Mode bits [7:6] select the edge of ext_trig that acts as a trigger: 0 none, 1 rising, 2 falling, 3 both. A trigger loads 0 into the counter and does not change whether the clock is enabled. Control bit2 is a software trigger with the same effect.
- R10: A tick taken at 0xFFFF, when RC is not 0xFFFF, wraps the counter to 0 and sets status bit1 (overflow).
- R11: Reading status (address 4) returns the flags {bit1 overflow, bit0 RC compare} and clears them. A flag event in the same cycle as the read leaves that flag set.
- R12: Writing address 5 sets mask bits and writing address 6 clears them, one bit per status flag. Reading address 5 returns the mask. irq is high exactly while some flag and its mask bit are both set, from the same edge on which the flag or mask changes.
- R13: Writes to RA (address 2) and RC (address 3) take effect immediately, including while the channel is running. Address 7 reads back the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| ext_clk | input | 3 | External clock / gate pins |
| ext_trig | input | 1 | External trigger pin |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency:
- A register write acts on the next rising edge.
- Read data appears one cycle after the read strobe, and the monitor compares it at the following falling edge.
- A change on an external pin is counted two edges after the pin is first sampled, because of the synchroniser.
- The counter, wave_out, the flags and irq all change on the same edge.

The bench holds each pin phase for four cycles and samples at the falling edge, so every check falls after its result is due. Internal-tap checks accept a one-tick window, because the prescaler phase is free-running. The overflow check waits on irq with a bounded timeout.

// File: rtl/tcw_pkg.sv
package tcw_pkg;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_MODE = 3'd1,
    A_RA   = 3'd2,
    A_RC   = 3'd3,
    A_STAT = 3'd4,
    A_IEN  = 3'd5,
    A_IDIS = 3'd6,
    A_CNT  = 3'd7
  } reg_addr_e;

  // mode word: bit8 one-shot, [7:6] trigger edge, [5:4] gate, 3 invert, [2:0] clock
  typedef struct packed {
    logic       stop_rc;
    logic [1:0] trg_edge;
    logic [1:0] gate_sel;
    logic       inv;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W   = $bits(mode_t);
  localparam int NUM_FLAG = 2;
  localparam int FLAG_RC  = 0;
  localparam int FLAG_OVF = 1;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_DIS = 1;
  localparam int CTRL_TRG = 2;

endpackage

// File: rtl/tcw_edge_sync.sv
module tcw_edge_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/tcw_tick_sel.sv
module tcw_tick_sel
  import tcw_pkg::*;
#(
  parameter int PRESC_W  = 10,
  parameter int NUM_TAPS = 5,
  parameter int NUM_EXT  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  mode_t              mode,
  input  logic [NUM_EXT-1:0] ext_lvl,
  input  logic [NUM_EXT-1:0] ext_rise,
  input  logic [NUM_EXT-1:0] ext_fall,
  output logic               tick
);
  // bit of the prescaler whose period gives divide 2, 8, 32, 128, 1024
  function automatic int tap_bit(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 4;
      3:       return 6;
      default: return 9;
    endcase
  endfunction

  logic [PRESC_W-1:0]  presc_q;
  logic [NUM_TAPS-1:0] tap_rise, tap_fall;
  logic                sel_edge, gate_ok;

  always_ff @(posedge clk) begin
    if (rst) presc_q <= '0;
    else     presc_q <= presc_q + 1'b1;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int B = tap_bit(t);
    localparam logic [PRESC_W-1:0] LOW_M = PRESC_W'((64'd1 << (B + 1)) - 64'd1);
    localparam logic [PRESC_W-1:0] TOP_V = PRESC_W'(64'd1 << B);
    assign tap_rise[t] = (presc_q & LOW_M) == TOP_V;
    assign tap_fall[t] = (presc_q & LOW_M) == '0;
  end

  always_comb begin
    sel_edge = 1'b0;
    for (int t = 0; t < NUM_TAPS; t++)
      if (32'(mode.clk_sel) == t)
        sel_edge = mode.inv ? tap_fall[t] : tap_rise[t];
    for (int e = 0; e < NUM_EXT; e++)
      if (32'(mode.clk_sel) == NUM_TAPS + e)
        sel_edge = mode.inv ? ext_fall[e] : ext_rise[e];
  end

  always_comb begin
    gate_ok = 1'b1;
    for (int e = 0; e < NUM_EXT; e++)
      if (32'(mode.gate_sel) == e + 1)
        gate_ok = ext_lvl[e];
  end

  assign tick = sel_edge & gate_ok;
endmodule

// File: rtl/tcw_count_core.sv
module tcw_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             trg,
  input  logic             stop_rc,
  input  logic [CNT_W-1:0] ra,
  input  logic [CNT_W-1:0] rc,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             wave,
  output logic             adv,
  output logic             rc_evt,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_q, cnt_step;
  logic             run_q, wave_q, ra_evt;

  always_comb begin
    cnt_step = (cnt_q == rc) ? '0 : cnt_q + 1'b1;
    adv      = run_q & tick & ~trg;
    rc_evt   = adv & (cnt_step == rc);
    ra_evt   = adv & (cnt_step == ra);
    ovf_evt  = adv & (&cnt_q) & (cnt_q != rc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (trg)      cnt_q <= '0;
      else if (adv) cnt_q <= cnt_step;

      if (cmd_dis)                 run_q <= 1'b0;
      else if (cmd_en)             run_q <= 1'b1;
      else if (stop_rc && rc_evt)  run_q <= 1'b0;

      if (trg || rc_evt) wave_q <= 1'b0;
      else if (ra_evt)   wave_q <= 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;
  assign wave    = wave_q;
endmodule

// File: rtl/tcw_channel.sv
module tcw_channel
  import tcw_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int NUM_EXT  = 3,
  parameter int PRESC_W  = 10,
  parameter int NUM_TAPS = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  output logic [CNT_W-1:0]   reg_rdata,
  input  logic [NUM_EXT-1:0] ext_clk,
  input  logic               ext_trig,
  output logic               wave_out,
  output logic               irq
);
  localparam int SYNC_W = NUM_EXT + 1;

  reg_addr_e          addr;
  mode_t              mode_q;
  logic [CNT_W-1:0]   ra_q, rc_q, cnt;
  logic [NUM_FLAG-1:0] flags_q, flags_d, mask_q, mask_d, evt_vec;
  logic [SYNC_W-1:0]  s_lvl, s_rise, s_fall;
  logic               wr_ctrl, cmd_en, cmd_dis, sw_trg, ext_trg, trg;
  logic               tick, running, wave, adv, rc_evt, ovf_evt, rd_stat;
  logic               irq_q;
  logic [CNT_W-1:0]   rdata_q;

  assign addr    = reg_addr_e'(reg_addr);
  assign wr_ctrl = reg_wr && (addr == A_CTRL);
  assign cmd_en  = wr_ctrl && reg_wdata[CTRL_EN];
  assign cmd_dis = wr_ctrl && reg_wdata[CTRL_DIS];
  assign sw_trg  = wr_ctrl && reg_wdata[CTRL_TRG];
  assign rd_stat = reg_rd && (addr == A_STAT);

  tcw_edge_sync #(.W(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ext_trig, ext_clk}),
    .lvl (s_lvl),
    .rise(s_rise),
    .fall(s_fall)
  );

  tcw_tick_sel #(
    .PRESC_W (PRESC_W),
    .NUM_TAPS(NUM_TAPS),
    .NUM_EXT (NUM_EXT)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .ext_lvl (s_lvl[NUM_EXT-1:0]),
    .ext_rise(s_rise[NUM_EXT-1:0]),
    .ext_fall(s_fall[NUM_EXT-1:0]),
    .tick    (tick)
  );

  always_comb begin
    case (mode_q.trg_edge)
      2'd1:    ext_trg = s_rise[NUM_EXT];
      2'd2:    ext_trg = s_fall[NUM_EXT];
      2'd3:    ext_trg = s_rise[NUM_EXT] | s_fall[NUM_EXT];
      default: ext_trg = 1'b0;
    endcase
  end
  assign trg = sw_trg | ext_trg;

  tcw_count_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cmd_en (cmd_en),
    .cmd_dis(cmd_dis),
    .trg    (trg),
    .stop_rc(mode_q.stop_rc),
    .ra     (ra_q),
    .rc     (rc_q),
    .cnt    (cnt),
    .running(running),
    .wave   (wave),
    .adv    (adv),
    .rc_evt (rc_evt),
    .ovf_evt(ovf_evt)
  );

  always_comb begin
    evt_vec           = '0;
    evt_vec[FLAG_RC]  = rc_evt;
    evt_vec[FLAG_OVF] = ovf_evt;
    flags_d = (rd_stat ? '0 : flags_q) | evt_vec;
    mask_d  = mask_q;
    if (reg_wr && addr == A_IEN)  mask_d = mask_d | reg_wdata[NUM_FLAG-1:0];
    if (reg_wr && addr == A_IDIS) mask_d = mask_d & ~reg_wdata[NUM_FLAG-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      ra_q    <= '0;
      rc_q    <= '0;
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (reg_wr && addr == A_MODE) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
      if (reg_wr && addr == A_RA)   ra_q   <= reg_wdata;
      if (reg_wr && addr == A_RC)   rc_q   <= reg_wdata;
      flags_q <= flags_d;
      mask_q  <= mask_d;
      irq_q   <= |(flags_d & mask_d);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (addr)
        A_MODE:  rdata_q <= CNT_W'(mode_q);
        A_RA:    rdata_q <= ra_q;
        A_RC:    rdata_q <= rc_q;
        A_STAT:  rdata_q <= CNT_W'(flags_q);
        A_IEN:   rdata_q <= CNT_W'(mask_q);
        A_CNT:   rdata_q <= cnt;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign wave_out  = wave;
  assign irq       = irq_q;
endmodule

// File: rtl/tcw_channel_chk.sv
module tcw_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rc,
  input logic             running,
  input logic             wave,
  input logic             irq,
  input logic             trg,
  input logic             adv,
  input logic             rc_evt,
  input logic             ovf_evt,
  input logic             stop_rc,
  input logic             cmd_en,
  input logic             cmd_dis,
  input logic [1:0]       flags
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt == '0 && !wave && !irq && !running)); // R1
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
    cmd_dis |=> !running); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!running && !trg) |=> $stable(cnt)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt != rc) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == rc) |=> (cnt == '0)); // R6
  AST_WAVE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rc_evt || trg) |=> !wave); // R7
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (rc_evt && stop_rc && !cmd_en) |=> !running); // R8
  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (rst)
    trg |=> (cnt == '0)); // R9
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> flags[1]); // R10
  AST_RC_FLAG: assert property (@(posedge clk) disable iff (rst)
    rc_evt |=> flags[0]); // R11
endmodule

bind tcw_channel tcw_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cnt    (cnt),
  .rc     (rc_q),
  .running(running),
  .wave   (wave_out),
  .irq    (irq),
  .trg    (trg),
  .adv    (adv),
  .rc_evt (rc_evt),
  .ovf_evt(ovf_evt),
  .stop_rc(mode_q.stop_rc),
  .cmd_en (cmd_en),
  .cmd_dis(cmd_dis),
  .flags  (flags_q)
);

// File: tb/tcw_channel_tb.sv
module tcw_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 195000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [2:0]  ext_clk = '0;
  logic        ext_trig = 1'b0;
  logic        wave_out, irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int    q_lo[$];
  int    q_hi[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tcw_channel u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_clk(ext_clk), .ext_trig(ext_trig), .wave_out(wave_out), .irq(irq)
  );

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input int lo, input int hi, input string tag);
    q_lo.push_back(lo); q_hi.push_back(hi); q_tag.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk[ch] = 1'b1; idle(4);
      ext_clk[ch] = 1'b0; idle(4);
    end
  endtask

  task automatic trig_pulse();
    @(negedge clk); ext_trig = 1'b1; idle(4);
    ext_trig = 1'b0; idle(4);
  endtask

  // scoreboard monitor: read data is due one cycle after the strobe
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd) begin
        @(negedge clk);
        checks++;
        if (q_lo.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: unexpected read, actual=%0d expected=none", reg_rdata);
        end else begin
          int lo, hi;
          string tg;
          lo = q_lo.pop_front(); hi = q_hi.pop_front(); tg = q_tag.pop_front();
          if (int'(reg_rdata) < lo || int'(reg_rdata) > hi) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tg, reg_rdata, lo, hi);
          end
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk(wave_out, 0, "R1 wave");
    chk(irq, 0, "R1 irq");
    rd_exp(3'd7, 0, 0, "R1 count");
    rd_exp(3'd4, 0, 0, "R1 status");
    rd_exp(3'd1, 0, 0, "R1 mode");
    rd_exp(3'd5, 0, 0, "R1 mask");
    pulse(0, 1);
    rd_exp(3'd7, 0, 0, "R1 clock disabled");

    // R3 external clock 0, R2 control
    wr(3'd3, 16'd100); wr(3'd2, 16'd50);
    wr(3'd1, 16'h0005);
    wr(3'd0, 16'h0005);
    pulse(0, 3);
    rd_exp(3'd7, 3, 3, "R3 ext clock count");
    wr(3'd0, 16'h0002);
    pulse(0, 2);
    rd_exp(3'd7, 3, 3, "R2 disabled holds");
    wr(3'd0, 16'h0003);
    pulse(0, 1);
    rd_exp(3'd7, 3, 3, "R2 disable wins");
    wr(3'd0, 16'h0001);
    pulse(0, 1);
    rd_exp(3'd7, 4, 4, "R2 enable keeps count");
    wr(3'd0, 16'h0005);
    rd_exp(3'd7, 0, 0, "R2 enable+trigger zero");

    // R4 invert
    wr(3'd1, 16'h000D);
    wr(3'd0, 16'h0005);
    @(negedge clk); ext_clk[0] = 1'b1; idle(4);
    rd_exp(3'd7, 0, 0, "R4 no count on rise");
    ext_clk[0] = 1'b0; idle(4);
    rd_exp(3'd7, 1, 1, "R4 count on fall");

    // R5 gating by ext_clk[1]
    wr(3'd1, 16'h0025);
    wr(3'd0, 16'h0005);
    pulse(0, 2);
    rd_exp(3'd7, 0, 0, "R5 gate low blocks");
    @(negedge clk); ext_clk[1] = 1'b1; idle(4);
    pulse(0, 2);
    rd_exp(3'd7, 2, 2, "R5 gate high passes");
    @(negedge clk); ext_clk[1] = 1'b0; idle(4);

    // R6 / R7 waveform and wrap
    wr(3'd1, 16'h0005); wr(3'd2, 16'd2); wr(3'd3, 16'd4);
    wr(3'd0, 16'h0005);
    rd_exp(3'd4, 0, 0, "R11 status clean");
    pulse(0, 1); chk(wave_out, 0, "R7 wave below RA");
    pulse(0, 1); chk(wave_out, 1, "R7 wave set at RA");
    pulse(0, 1); chk(wave_out, 1, "R7 wave held");
    pulse(0, 1); chk(wave_out, 0, "R7 wave cleared at RC");
    rd_exp(3'd4, 1, 1, "R6 RC flag");
    rd_exp(3'd4, 0, 0, "R11 read clears");
    pulse(0, 1);
    rd_exp(3'd7, 0, 0, "R6 wrap to zero");
    pulse(0, 2); chk(wave_out, 1, "R7 wave set again");
    wr(3'd0, 16'h0004);
    chk(wave_out, 0, "R7 trigger clears wave");
    rd_exp(3'd7, 0, 0, "R9 sw trigger zero");
    pulse(0, 1);
    rd_exp(3'd7, 1, 1, "R9 trigger keeps running");
    wr(3'd2, 16'd4);
    pulse(0, 3); chk(wave_out, 0, "R7 RC wins when RA equals RC");
    rd_exp(3'd4, 1, 1, "R6 RC flag again");

    // R8 one-shot
    wr(3'd1, 16'h0105); wr(3'd3, 16'd3); wr(3'd2, 16'd1);
    wr(3'd0, 16'h0005);
    pulse(0, 5);
    rd_exp(3'd7, 3, 3, "R8 stops at RC");
    wr(3'd0, 16'h0001);
    pulse(0, 1);
    rd_exp(3'd7, 0, 0, "R8 resumes after enable");
    pulse(0, 4);
    rd_exp(3'd7, 3, 3, "R8 stops again");

    // R13 RC write while running
    wr(3'd1, 16'h0005); wr(3'd3, 16'd100);
    wr(3'd0, 16'h0005);
    rd_exp(3'd4, 0, 3, "R11 clear before R13");
    pulse(0, 3);
    wr(3'd3, 16'd4);
    pulse(0, 1);
    rd_exp(3'd4, 1, 1, "R13 new RC matched");
    pulse(0, 1);
    rd_exp(3'd7, 0, 0, "R13 wrap at new RC");
    rd_exp(3'd3, 4, 4, "R13 RC readback");
    wr(3'd3, 16'd100);

    // R9 external trigger edges
    wr(3'd1, 16'h0045);
    wr(3'd0, 16'h0005);
    pulse(0, 3);
    trig_pulse();
    rd_exp(3'd7, 0, 0, "R9 rising trigger");
    pulse(0, 2);
    wr(3'd1, 16'h0085);
    @(negedge clk); ext_trig = 1'b1; idle(4);
    rd_exp(3'd7, 2, 2, "R9 rise ignored in falling mode");
    ext_trig = 1'b0; idle(4);
    rd_exp(3'd7, 0, 0, "R9 falling trigger");
    wr(3'd1, 16'h0005);
    pulse(0, 1);
    trig_pulse();
    rd_exp(3'd7, 1, 1, "R9 no trigger edge selected");
    wr(3'd1, 16'h00C5);
    pulse(0, 2);
    @(negedge clk); ext_trig = 1'b1; idle(4);
    rd_exp(3'd7, 0, 0, "R9 both edges rise");
    pulse(0, 1);
    ext_trig = 1'b0; idle(4);
    rd_exp(3'd7, 0, 0, "R9 both edges fall");

    // R12 interrupt mask
    wr(3'd1, 16'h0005); wr(3'd3, 16'd2);
    rd_exp(3'd4, 0, 3, "R11 clear before R12");
    wr(3'd5, 16'h0001);
    wr(3'd0, 16'h0005);
    chk(irq, 0, "R12 irq low without flag");
    pulse(0, 2);
    chk(irq, 1, "R12 irq on masked flag");
    rd_exp(3'd5, 1, 1, "R12 mask readback");
    wr(3'd6, 16'h0001);
    chk(irq, 0, "R12 irq low after mask clear");
    rd_exp(3'd4, 1, 1, "R12 flag still set");
    wr(3'd5, 16'h0001);
    chk(irq, 0, "R12 irq low after flag read");
    wr(3'd6, 16'h0001);

    // R3 internal taps
    wr(3'd3, 16'hFFFF);
    wr(3'd1, 16'h0001); wr(3'd0, 16'h0005);
    idle(80);
    rd_exp(3'd7, 9, 11, "R3 divide by 8");
    wr(3'd1, 16'h0000); wr(3'd0, 16'h0005);
    idle(40);
    rd_exp(3'd7, 19, 22, "R3 divide by 2");
    wr(3'd1, 16'h0004); wr(3'd0, 16'h0005);
    idle(2100);
    rd_exp(3'd7, 1, 3, "R3 divide by 1024");

    // R10 overflow with RC written below the count
    wr(3'd1, 16'h0005); wr(3'd3, 16'd100);
    wr(3'd0, 16'h0005);
    pulse(0, 5);
    wr(3'd3, 16'd2);
    rd_exp(3'd4, 0, 3, "R11 clear before R10");
    wr(3'd6, 16'h0003);
    wr(3'd5, 16'h0002);
    wr(3'd1, 16'h0000);
    for (int k = 0; k < 140000 && !irq; k++) @(negedge clk);
    chk(irq, 1, "R10 overflow irq");
    wr(3'd0, 16'h0002);
    rd_exp(3'd4, 2, 3, "R10 overflow flag");
    rd_exp(3'd4, 0, 0, "R11 flags cleared");
    chk(irq, 0, "R12 irq drops after read");

    idle(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule